// File: doc/BRIEF.md
# Fixed-Range Memory Type Resolver

This block decides the caching memory type for a physical address in a processor memory subsystem. It holds one 64-bit control register and eleven 64-bit fixed-range registers. Together the fixed-range registers split the first megabyte of physical space into 88 sub-ranges, each with its own 8-bit type field. Software reaches all twelve registers through a single write/read port that has a register index, write data, combinational read data and a fault pulse.

A lookup presents a physical address together with the result of a separately resolved variable-range match: a hit flag and its type. The registered response comes back on the next cycle. The resolver applies a strict priority:

1. The global enable flag decides first. When it is clear, the type is uncacheable.
2. The fixed-range field applies next, but only while the fixed-range enable is set and the address is below 100000h.
3. The variable-range result applies after that.
4. The default type field in the control register applies last.

Top module: `mtr_resolver`

## Requirements
- R1: After reset all twelve registers read as zero, `wr_fault` and `rsp_valid` are low, and every lookup returns type 00h (uncacheable).
- R2: Register index 0 is the control register. Its bits 7:0 hold the default type, bit 10 is the fixed-range enable, and bit 11 is the global enable. A legal write to it reads back unchanged.
- R3: A write to index 0 with any of bits 8, 9 or 63:12 set is rejected. The register keeps its old value, and `wr_fault` is high for exactly the one cycle after the write.
- R4: Indices 1 to 11 hold fixed-range registers 0 to 10. Any 64-bit value is accepted without a fault and reads back unchanged.
- R5: A write to an index from 12 to 15 raises the fault pulse and changes no register. A read of such an index returns zero.
- R6: While the global enable (bit 11) is clear, every lookup returns 00h, whatever the fixed-range enable, the address and the variable-range inputs are.
- R7: While both enables are set and the address is below 100000h, the fixed-range field is returned even when `var_hit` is high.
- R8: While the global enable is set and the fixed-range enable is clear, an address below 100000h returns `var_type` when `var_hit` is high, and the default type otherwise.
- R9: While the global enable is set, an address that hits neither a fixed field nor a variable range returns the default type.
- R10: Fixed-range register 0 covers 00000h to 7FFFFh in eight 64 KB sub-ranges. Sub-range k uses bits 8k+7:8k, so the lowest sub-range is in bits 7:0.
- R11: Fixed-range registers 1 and 2 cover 80000h to 9FFFFh and A0000h to BFFFFh, each as eight 16 KB sub-ranges, with the lowest sub-range in bits 7:0.
- R12: Fixed-range registers 3 to 10 each cover 32 KB in order from C0000h to FFFFFh, as eight 4 KB sub-ranges, with the lowest sub-range in bits 7:0.
- R13: An address at or above 100000h never uses a fixed field. It resolves through the variable-range inputs and then the default type.
- R14: `rsp_valid` is the value `lk_valid` had one cycle earlier. `rsp_type` is the type resolved from the address, the variable-range inputs and the register contents present in that request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index for write and read |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the indexed register (combinational) |
| wr_fault | output | 1 | One-cycle pulse after a rejected write |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 36 | Physical address to resolve |
| var_hit | input | 1 | Variable-range match for `lk_addr` |
| var_type | input | 8 | Type of the variable-range match |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_type | output | 8 | Resolved memory type |

## Verification
Some properties hold on every cycle, and the assertions check them there:
- the fault pulse and the unchanged control register after a reserved or out-of-range write;
- the zero read of unimplemented indices;
- the uncacheable result under global disable;
- the pass-through of the variable type when fixed ranges are off;
- the default type above the first megabyte;
- field selection in the 64 KB region;
- the one-cycle response timing.

The finer 16 KB and 4 KB field layouts, and the priority of a fixed field over a variable hit across all eleven registers, can only be shown by the bench scenarios. Those scenarios fill every register with distinct field values and then probe addresses in every region under each combination of enables.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    localparam int unsigned MT_W       = 8;
    localparam int unsigned REG_W      = 64;
    localparam int unsigned FLD_PER_RG = 8;
    localparam logic [MT_W-1:0] MT_UNCACHED = 8'h00;

    localparam int unsigned CTL_FE_BIT = 10;
    localparam int unsigned CTL_E_BIT  = 11;
    localparam logic [REG_W-1:0] CTL_RSV_MASK = 64'hFFFF_FFFF_FFFF_F300;

    typedef struct packed {
        logic            glb_en;
        logic            fix_en;
        logic [MT_W-1:0] dflt;
    } ctl_t;

    typedef struct packed {
        logic       in_fixed;
        logic [3:0] rg;
        logic [2:0] fld;
    } fix_sel_t;

    typedef enum logic [1:0] {
        SRC_UC   = 2'd0,
        SRC_FIX  = 2'd1,
        SRC_VAR  = 2'd2,
        SRC_DFLT = 2'd3
    } mt_src_e;

    function automatic ctl_t ctl_decode(input logic [REG_W-1:0] raw);
        ctl_t c;
        c.glb_en = raw[CTL_E_BIT];
        c.fix_en = raw[CTL_FE_BIT];
        c.dflt   = raw[MT_W-1:0];
        return c;
    endfunction

    function automatic logic ctl_rsv_set(input logic [REG_W-1:0] raw);
        return |(raw & CTL_RSV_MASK);
    endfunction

    function automatic logic [MT_W-1:0] pick_field(input logic [REG_W-1:0] rg,
                                                   input logic [2:0] fld);
        logic [MT_W-1:0] r;
        r = '0;
        for (int i = 0; i < FLD_PER_RG; i++) begin
            if (fld == 3'(i)) r = rg[i*MT_W +: MT_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/mtr_regfile.sv
module mtr_regfile
    import mtr_pkg::*;
#(
    parameter int unsigned NFIX  = 11,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             fault,
    output logic [REG_W-1:0] ctl_q,
    output logic [REG_W-1:0] fix_q [NFIX]
);
    localparam int unsigned NREG = NFIX + 1;

    logic idx_ok;
    logic rsv_hit;
    logic ctl_wr_ok;
    logic wr_bad;

    always_comb begin
        idx_ok    = (idx < IDX_W'(NREG));
        rsv_hit   = ctl_rsv_set(wdata);
        ctl_wr_ok = wr_en && (idx == '0) && !rsv_hit;
        wr_bad    = wr_en && (!idx_ok || ((idx == '0) && rsv_hit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            fault <= 1'b0;
        end else begin
            if (ctl_wr_ok) ctl_q <= wdata;
            fault <= wr_bad;
        end
    end

    for (genvar g = 0; g < NFIX; g++) begin : g_fix
        always_ff @(posedge clk) begin
            if (rst) begin
                fix_q[g] <= '0;
            end else if (wr_en && (idx == IDX_W'(g + 1))) begin
                fix_q[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (idx == '0) rdata = ctl_q;
        for (int i = 0; i < NFIX; i++) begin
            if (idx == IDX_W'(i + 1)) rdata = fix_q[i];
        end
    end

endmodule

// File: rtl/mtr_fix_decode.sv
module mtr_fix_decode
    import mtr_pkg::*;
#(
    parameter int unsigned PA_W = 36
) (
    input  logic [PA_W-1:0] addr,
    output fix_sel_t        sel
);
    // The first megabyte is split by bit 19 (64 KB half) and bit 18 (16 KB quarter).
    always_comb begin
        sel.in_fixed = (addr[PA_W-1:20] == '0);
        if (!addr[19]) begin
            sel.rg  = 4'd0;
            sel.fld = addr[18:16];
        end else if (!addr[18]) begin
            sel.rg  = 4'd1 + {3'd0, addr[17]};
            sel.fld = addr[16:14];
        end else begin
            sel.rg  = 4'd3 + {1'b0, addr[17:15]};
            sel.fld = addr[14:12];
        end
    end

endmodule

// File: rtl/mtr_type_select.sv
module mtr_type_select
    import mtr_pkg::*;
#(
    parameter int unsigned NFIX = 11
) (
    input  ctl_t             ctl,
    input  fix_sel_t         sel,
    input  logic [REG_W-1:0] fix_q [NFIX],
    input  logic             var_hit,
    input  logic [MT_W-1:0]  var_type,
    output logic [MT_W-1:0]  mtype,
    output mt_src_e          src
);
    logic [MT_W-1:0] fix_fld;

    always_comb begin
        fix_fld = '0;
        for (int i = 0; i < NFIX; i++) begin
            if (sel.rg == 4'(i)) fix_fld = pick_field(fix_q[i], sel.fld);
        end
    end

    always_comb begin
        if (!ctl.glb_en) begin
            src   = SRC_UC;
            mtype = MT_UNCACHED;
        end else if (ctl.fix_en && sel.in_fixed) begin
            src   = SRC_FIX;
            mtype = fix_fld;
        end else if (var_hit) begin
            src   = SRC_VAR;
            mtype = var_type;
        end else begin
            src   = SRC_DFLT;
            mtype = ctl.dflt;
        end
    end

endmodule

// File: rtl/mtr_resolver.sv
module mtr_resolver
    import mtr_pkg::*;
#(
    parameter int unsigned PA_W  = 36,
    parameter int unsigned NFIX  = 11,
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [63:0]      reg_wdata,
    output logic [63:0]      reg_rdata,
    output logic             wr_fault,
    input  logic             lk_valid,
    input  logic [PA_W-1:0]  lk_addr,
    input  logic             var_hit,
    input  logic [7:0]       var_type,
    output logic             rsp_valid,
    output logic [7:0]       rsp_type
);
    logic [REG_W-1:0] ctl_q;
    logic [REG_W-1:0] fix_q [NFIX];
    ctl_t             ctl;
    fix_sel_t         sel;
    logic [MT_W-1:0]  mtype;
    mt_src_e          src;

    mtr_regfile #(.NFIX(NFIX), .IDX_W(IDX_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .idx   (reg_idx),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .fault (wr_fault),
        .ctl_q (ctl_q),
        .fix_q (fix_q)
    );

    assign ctl = ctl_decode(ctl_q);

    mtr_fix_decode #(.PA_W(PA_W)) u_dec (
        .addr (lk_addr),
        .sel  (sel)
    );

    mtr_type_select #(.NFIX(NFIX)) u_sel (
        .ctl      (ctl),
        .sel      (sel),
        .fix_q    (fix_q),
        .var_hit  (var_hit),
        .var_type (var_type),
        .mtype    (mtype),
        .src      (src)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_type  <= MT_UNCACHED;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) rsp_type <= mtype;
        end
    end

endmodule

// File: rtl/mtr_resolver_chk.sv
module mtr_resolver_chk #(
    parameter int unsigned PA_W  = 36,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned NREG  = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [IDX_W-1:0] reg_idx,
    input logic [63:0]      reg_wdata,
    input logic [63:0]      reg_rdata,
    input logic             wr_fault,
    input logic             lk_valid,
    input logic [PA_W-1:0]  lk_addr,
    input logic             var_hit,
    input logic [7:0]       var_type,
    input logic             rsp_valid,
    input logic [7:0]       rsp_type,
    input logic [63:0]      ctl_reg,
    input logic [63:0]      fix0_reg
);
    logic       rsv_wr;
    logic       oor_idx;
    logic       hi_addr;
    logic       lo64k;
    logic [7:0] f64_exp;

    always_comb begin
        rsv_wr  = reg_wr && (reg_idx == '0) && (|reg_wdata[63:12] || |reg_wdata[9:8]);
        oor_idx = (reg_idx >= IDX_W'(NREG));
        hi_addr = (lk_addr >= PA_W'(36'h10_0000));
        lo64k   = (lk_addr < PA_W'(36'h8_0000));
        f64_exp = fix0_reg[{3'd0, lk_addr[18:16]} * 6'd8 +: 8];
    end

    AST_RSV_FAULT: assert property (@(posedge clk) disable iff (rst)
        rsv_wr |=> wr_fault && (ctl_reg == $past(ctl_reg))); // R3

    AST_OOR_FAULT: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && oor_idx) |=> wr_fault && (ctl_reg == $past(ctl_reg))); // R5

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        oor_idx |-> (reg_rdata == 64'd0)); // R5

    AST_GLOBAL_OFF_UC: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !ctl_reg[11]) |=> (rsp_type == 8'h00)); // R6

    AST_FIX_OFF_VAR: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && ctl_reg[11] && !ctl_reg[10] && var_hit) |=> (rsp_type == $past(var_type))); // R8

    AST_HIGH_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && ctl_reg[11] && hi_addr && !var_hit) |=> (rsp_type == $past(ctl_reg[7:0]))); // R13

    AST_FIX64K_FIELD: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && ctl_reg[11] && ctl_reg[10] && lo64k) |=> (rsp_type == $past(f64_exp))); // R10

    AST_RSP_TIMING: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rsp_valid == $past(lk_valid))); // R14

endmodule

bind mtr_resolver mtr_resolver_chk #(.PA_W(PA_W), .IDX_W(IDX_W), .NREG(NFIX + 1)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .wr_fault  (wr_fault),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .var_hit   (var_hit),
    .var_type  (var_type),
    .rsp_valid (rsp_valid),
    .rsp_type  (rsp_type),
    .ctl_reg   (ctl_q),
    .fix0_reg  (fix_q[0])
);

// File: tb/test_mtr_resolver.sv
`timescale 1ns/1ps
module test_mtr_resolver;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        wr_fault;
    logic        lk_valid = 1'b0;
    logic [35:0] lk_addr = '0;
    logic        var_hit = 1'b0;
    logic [7:0]  var_type = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_type;

    always #2.5 clk = ~clk;

    mtr_resolver i_mtr_resolver (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wr_fault(wr_fault),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .var_hit(var_hit),
        .var_type(var_type), .rsp_valid(rsp_valid), .rsp_type(rsp_type)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
        logic [35:0] addr;
    } item_t;
    item_t sb[$];

    logic [63:0] m_ctl = '0;
    logic [63:0] m_fix [11];

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [35:0] a, input bit hit, input logic [7:0] vt);
        int unsigned rg, fd, off;
        if (!m_ctl[11]) return 8'h00;
        if (m_ctl[10] && a < 36'h10_0000) begin
            if (a < 36'h8_0000) begin
                rg = 0; fd = int'(a) / 32'h1_0000;
            end else if (a < 36'hC_0000) begin
                off = int'(a) - 32'h8_0000;
                rg = 1 + off / 32'h2_0000; fd = (off % 32'h2_0000) / 32'h4000;
            end else begin
                off = int'(a) - 32'hC_0000;
                rg = 3 + off / 32'h8000; fd = (off % 32'h8000) / 32'h1000;
            end
            return m_fix[rg][fd*8 +: 8];
        end
        if (hit) return vt;
        return m_ctl[7:0];
    endfunction

    task automatic wr(input logic [3:0] idx, input logic [63:0] d, input bit exp_fault, input string tag);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        check(wr_fault == exp_fault, tag, {63'd0, wr_fault}, {63'd0, exp_fault});
        if (!exp_fault) begin
            if (idx == 0) m_ctl = d;
            else if (idx < 12) m_fix[idx-1] = d;
        end
    endtask

    task automatic rd(input logic [3:0] idx, input logic [63:0] exp, input string tag);
        reg_idx = idx;
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic look(input logic [35:0] a, input bit hit, input logic [7:0] vt, input string tag);
        item_t it;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; var_hit = hit; var_type = vt;
        it.exp = model(a, hit, vt); it.tag = tag; it.addr = a;
        sb.push_back(it);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    // Monitor: each response must match the oldest expected item (R14 timing).
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R14 unexpected response", {56'd0, rsp_type}, 64'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(rsp_type == it.exp, it.tag, {56'd0, rsp_type}, {56'd0, it.exp});
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 11; i++) m_fix[i] = '0;
        repeat (3) @(negedge clk);
        check(wr_fault == 1'b0 && rsp_valid == 1'b0, "R1 outputs in reset", {62'd0, wr_fault, rsp_valid}, 64'd0);
        rst = 1'b0;
        for (int i = 0; i < 12; i++) rd(4'(i), 64'd0, "R1 register zero after reset");
        look(36'h0_0000, 1'b1, 8'h06, "R1 uncacheable after reset");
        look(36'h2_0000_0000, 1'b0, 8'h00, "R1 uncacheable above 1M after reset");

        // control register
        wr(4'd0, 64'h806, 1'b0, "R2 legal control write");
        rd(4'd0, 64'h806, "R2 control readback");
        look(36'h20_0000, 1'b0, 8'h05, "R9 default type above 1M");
        look(36'h20_0000, 1'b1, 8'h05, "R13 variable hit above 1M");

        // reserved bits
        wr(4'd0, 64'h906, 1'b1, "R3 bit 8 rejected");
        @(negedge clk);
        check(wr_fault == 1'b0, "R3 fault is one cycle", {63'd0, wr_fault}, 64'd0);
        wr(4'd0, 64'h1806, 1'b1, "R3 bit 12 rejected");
        wr(4'd0, 64'h8000_0000_0000_0806, 1'b1, "R3 bit 63 rejected");
        wr(4'd0, 64'h206, 1'b1, "R3 bit 9 rejected");
        rd(4'd0, 64'h806, "R3 control unchanged");

        // fixed registers with distinct fields
        for (int r = 0; r < 11; r++) begin
            logic [63:0] v;
            for (int f = 0; f < 8; f++) v[f*8 +: 8] = 8'((r + 1) * 16 + f);
            wr(4'(r + 1), v, 1'b0, "R4 fixed write accepted");
        end
        wr(4'd5, 64'hFFFF_0000_0000_FF00 | m_fix[4], 1'b0, "R4 all-bit value accepted");
        for (int r = 0; r < 11; r++) rd(4'(r + 1), m_fix[r], "R4 fixed readback");

        // out-of-range indices
        wr(4'd12, 64'h1234, 1'b1, "R5 index 12 write faults");
        wr(4'd15, 64'hC07, 1'b1, "R5 index 15 write faults");
        rd(4'd13, 64'd0, "R5 out-of-range read zero");
        rd(4'd0, 64'h806, "R5 control untouched");
        rd(4'd1, m_fix[0], "R5 fixed untouched");

        // fixed lookup with both enables
        wr(4'd0, 64'hC06, 1'b0, "R2 set both enables");
        for (int k = 0; k < 8; k++) look(36'(k * 32'h1_0000 + 32'h123), 1'b1, 8'h05, "R10 64K field over var hit");
        for (int k = 0; k < 16; k++) look(36'(32'h8_0000 + k * 32'h4000 + 32'h3FF0), 1'b1, 8'h05, "R11 16K field");
        for (int k = 0; k < 64; k++) look(36'(32'hC_0000 + k * 32'h1000 + 32'h800), 1'b0, 8'h05, "R12 4K field");
        look(36'h0_FFFF, 1'b1, 8'h04, "R7 fixed priority at 64K edge");
        look(36'hF_FFFF, 1'b1, 8'h04, "R7 fixed priority at top of 1M");
        look(36'h10_0000, 1'b1, 8'h04, "R13 first address above fixed region var");
        look(36'h10_0000, 1'b0, 8'h04, "R13 first address above fixed region default");
        look(36'h8_0010_0000, 1'b0, 8'h04, "R13 alias of low bits not fixed");

        // fixed disabled
        wr(4'd0, 64'h801, 1'b0, "R2 fixed disabled");
        look(36'h4_0000, 1'b1, 8'h05, "R8 var hit in low region");
        look(36'h4_0000, 1'b0, 8'h05, "R8 default in low region");
        look(36'hC_8000, 1'b0, 8'h05, "R9 default with nothing matched");

        // global disabled
        wr(4'd0, 64'h406, 1'b0, "R6 global disabled");
        look(36'h4_0000, 1'b1, 8'h05, "R6 fixed region gives UC");
        look(36'h30_0000, 1'b1, 8'h05, "R6 var hit gives UC");
        look(36'h30_0000, 1'b0, 8'h05, "R6 default gives UC");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R14 all responses returned", 64'(sb.size()), 64'd0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule